// File: doc/BRIEF.md
# 16-bit ALU with Overflow Register

This block is the execution stage of a small 16-bit processor. Each cycle it may accept one operation, given as a 3-bit code, two already resolved operand values and a flag that says whether the destination is the overflow register. On the next rising clock edge it writes the 16-bit result to the destination write-back port, and it updates the internal overflow register (called O below) with the companion value that the operation defines.

The supported operations are set, add, multiply, divide, modulo, logical shift right and bitwise OR. Add, multiply, divide and shift right each define a companion value for O: the carry, the upper product half, the binary fraction of the quotient, and the bits shifted out. Set, OR and modulo leave O alone. When O is itself the destination, the result does not go out on the write-back port. O then takes the companion value if the operation defines one, and the result otherwise. Division and modulo by zero give zero.

Fetch, addressing modes and memory live outside the block. The caller reads the current O value from `ovfOut` whenever an operand refers to O.

Top module: `ovf_alu`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `ovfOut` to 0 and `wbValid` to 0 after that edge.
- R2: Add (opCode 1) writes (a+b) mod 2^16 and sets O to 1 on carry out, otherwise to 0, so an add without carry clears a set O.
- R3: Multiply (opCode 2) writes the low 16 bits of a*b and puts the upper 16 bits in O.
- R4: Divide (opCode 3) writes floor(a/b) and sets O to ((a<<16)/b) mod 2^16. When b is 0 both the result and O are 0.
- R5: Modulo (opCode 4) writes a mod b, writes 0 when b is 0, and leaves O unchanged.
- R6: Shift right (opCode 5) uses only b[3:0] as the amount s. It writes a>>s and sets O to the s bits shifted out, right-aligned (a & (2^s-1)).
- R7: Bitwise OR (opCode 6) writes a|b and leaves O unchanged.
- R8: Set (opCode 0) writes b and leaves O unchanged.
- R9: With `dstIsOvf` high, `wbValid` stays low. O takes the companion value for add, multiply, divide and shift right, and takes the result for set, OR and modulo.
- R10: Results appear on the edge that samples `opValid` high. A cycle with `opValid` low gives `wbValid` low and leaves O unchanged.
- R11: opCode 7 is reserved: it raises no write-back and leaves O unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 3 | Operation code (see requirements) |
| opA | input | 16 | First operand (destination's old value) |
| opB | input | 16 | Second operand |
| dstIsOvf | input | 1 | Destination is the overflow register |
| wbValid | output | 1 | Destination write strobe, registered |
| wbData | output | 16 | Destination write data, registered |
| ovfOut | output | 16 | Current overflow register value |

## Verification
The bench builds the block with its default data width of 16. At that width the shift-amount field is exactly 4 bits, so a shift of 20 folds onto a shift of 4, and the 32-bit carry, product and fraction values can be checked against plain integer arithmetic in the bench's model. This width also reaches the extreme operands: 0xFFFF squared, carry from 0xFFFE plus 5, a shift of 15, and a shift of 0 that must leave O empty.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;

  typedef enum logic [2:0] {
    OP_SET  = 3'd0,
    OP_ADD  = 3'd1,
    OP_MUL  = 3'd2,
    OP_DIV  = 3'd3,
    OP_MOD  = 3'd4,
    OP_SHR  = 3'd5,
    OP_BOR  = 3'd6,
    OP_RSVD = 3'd7
  } alu_op_e;

  // Strobes from control to datapath
  typedef struct packed {
    alu_op_e resSel;        // which function drives the result
    logic    dstWrite;      // write-back to ordinary destination
    logic    ovfWrite;      // O is updated this edge
    logic    ovfFromResult; // O takes the result rather than the companion
  } alu_strobe_t;

endpackage

// File: rtl/ovf_alu_divider.sv
module ovf_alu_divider #(
  parameter int W = 16
) (
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic [W-1:0] frac,
  output logic [W-1:0] rem
);
  localparam int WW = 2 * W;

  logic [WW-1:0] wideNum;
  logic [WW-1:0] wideDen;
  logic [WW-1:0] wideQuo;
  logic          denZero;

  assign denZero = (den == '0);
  assign wideNum = {num, {W{1'b0}}};
  assign wideDen = {{W{1'b0}}, den};

  // One wide division yields the integer part (upper half)
  // and the binary fraction (lower half) together.
  always_comb begin
    if (denZero) begin
      wideQuo = '0;
      rem     = '0;
    end else begin
      wideQuo = wideNum / wideDen;
      rem     = num % den;
    end
  end

  assign quo  = wideQuo[WW-1:W];
  assign frac = wideQuo[W-1:0];

endmodule

// File: rtl/ovf_alu_ctrl.sv
module ovf_alu_ctrl
  import ovf_alu_pkg::*;
(
  input  logic        opValid,
  input  logic [2:0]  opCode,
  input  logic        dstIsOvf,
  output alu_strobe_t strobe
);
  alu_op_e op;
  logic    known;
  logic    hasCompanion;

  assign op = alu_op_e'(opCode);

  always_comb begin
    known        = 1'b1;
    hasCompanion = 1'b0;
    unique case (op)
      OP_ADD, OP_MUL, OP_DIV, OP_SHR: hasCompanion = 1'b1;
      OP_SET, OP_MOD, OP_BOR:         hasCompanion = 1'b0;
      default:                        known        = 1'b0;
    endcase
  end

  always_comb begin
    strobe.resSel        = op;
    strobe.dstWrite      = opValid && known && !dstIsOvf;
    strobe.ovfWrite      = opValid && known && (hasCompanion || dstIsOvf);
    strobe.ovfFromResult = dstIsOvf && !hasCompanion;
  end

endmodule

// File: rtl/ovf_alu_datapath.sv
module ovf_alu_datapath
  import ovf_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  alu_strobe_t strobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic        wbValid,
  output logic [W-1:0] wbData,
  output logic [W-1:0] ovfOut
);
  localparam int SHW = $clog2(W);
  localparam int WW  = 2 * W;

  logic [W:0]     sumFull;
  logic [WW-1:0]  prodFull;
  logic [W-1:0]   divQuo;
  logic [W-1:0]   divFrac;
  logic [W-1:0]   modRem;
  logic [SHW-1:0] shAmt;
  logic [W-1:0]   shrVal;
  logic [W-1:0]   shrLost;
  logic [W-1:0]   resVal;
  logic [W-1:0]   compVal;
  logic [W-1:0]   ovfReg;

  assign sumFull  = {1'b0, opA} + {1'b0, opB};
  assign prodFull = {{W{1'b0}}, opA} * {{W{1'b0}}, opB};

  ovf_alu_divider #(.W(W)) u_div (
    .num  (opA),
    .den  (opB),
    .quo  (divQuo),
    .frac (divFrac),
    .rem  (modRem)
  );

  assign shAmt   = opB[SHW-1:0];
  assign shrVal  = opA >> shAmt;
  assign shrLost = opA & ~({W{1'b1}} << shAmt);

  always_comb begin
    resVal  = '0;
    compVal = '0;
    case (strobe.resSel)
      OP_SET: resVal = opB;
      OP_ADD: begin
        resVal  = sumFull[W-1:0];
        compVal = {{(W-1){1'b0}}, sumFull[W]};
      end
      OP_MUL: begin
        resVal  = prodFull[W-1:0];
        compVal = prodFull[WW-1:W];
      end
      OP_DIV: begin
        resVal  = divQuo;
        compVal = divFrac;
      end
      OP_MOD: resVal = modRem;
      OP_SHR: begin
        resVal  = shrVal;
        compVal = shrLost;
      end
      OP_BOR: resVal = opA | opB;
      default: begin
        resVal  = '0;
        compVal = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbValid <= 1'b0;
      wbData  <= '0;
      ovfReg  <= '0;
    end else begin
      wbValid <= strobe.dstWrite;
      if (strobe.dstWrite) wbData <= resVal;
      if (strobe.ovfWrite) ovfReg <= strobe.ovfFromResult ? resVal : compVal;
    end
  end

  assign ovfOut = ovfReg;

endmodule

// File: rtl/ovf_alu.sv
module ovf_alu
  import ovf_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         opValid,
  input  logic [2:0]   opCode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         dstIsOvf,
  output logic         wbValid,
  output logic [W-1:0] wbData,
  output logic [W-1:0] ovfOut
);
  alu_strobe_t strobe;

  ovf_alu_ctrl u_ctrl (
    .opValid  (opValid),
    .opCode   (opCode),
    .dstIsOvf (dstIsOvf),
    .strobe   (strobe)
  );

  ovf_alu_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .wbValid (wbValid),
    .wbData  (wbData),
    .ovfOut  (ovfOut)
  );

endmodule

// File: rtl/ovf_alu_checker.sv
module ovf_alu_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         opValid,
  input logic [2:0]   opCode,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         dstIsOvf,
  input logic         wbValid,
  input logic [W-1:0] wbData,
  input logic [W-1:0] ovfOut
);
  localparam int WW = 2 * W;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ovfOut == '0) && !wbValid);

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> !wbValid && $stable(ovfOut));

  a_r9_no_writeback: assert property (@(posedge clk) disable iff (rst)
    (opValid && dstIsOvf) |=> !wbValid);

  a_r2_carry_bit: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 3'd1 && !dstIsOvf) |=> (ovfOut <= 1) && wbValid);

  a_r3_product: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 3'd2 && !dstIsOvf) |=>
      ({ovfOut, wbData} == ({{W{1'b0}}, $past(opA)} * {{W{1'b0}}, $past(opB)})));

  a_r4_div_zero: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 3'd3 && opB == '0 && !dstIsOvf) |=>
      (ovfOut == '0) && (wbData == '0));

  a_r7_or_keeps_ovf: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 3'd6 && !dstIsOvf) |=> ovfOut == $past(ovfOut));

  a_r11_reserved: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 3'd7) |=> !wbValid && $stable(ovfOut));

  logic [WW-1:0] unusedWide;
  assign unusedWide = '0;

endmodule

bind ovf_alu ovf_alu_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opValid  (opValid),
  .opCode   (opCode),
  .opA      (opA),
  .opB      (opB),
  .dstIsOvf (dstIsOvf),
  .wbValid  (wbValid),
  .wbData   (wbData),
  .ovfOut   (ovfOut)
);

// File: tb/ovf_alu_bench.sv
`timescale 1ns/1ps
module ovf_alu_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         opValid = 1'b0;
  logic [2:0]   opCode = 3'd0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         dstIsOvf = 1'b0;
  logic         wbValid;
  logic [W-1:0] wbData;
  logic [W-1:0] ovfOut;

  always #4 clk = ~clk;  // 125 MHz

  ovf_alu #(.W(W)) u_ovf_alu (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .dstIsOvf(dstIsOvf),
    .wbValid(wbValid), .wbData(wbData), .ovfOut(ovfOut)
  );

  typedef struct {
    logic        expValid;
    logic [15:0] expData;
    logic [15:0] expOvf;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic [15:0] modelO = 16'h0;
  bit finished = 0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Driver: present one operation and push the expected outcome
  task automatic doOp(int op, int a, int b, bit dst, string tag);
    exp_t e;
    longint r;
    longint c;
    bit hasC;
    int s;
    @(negedge clk);
    opValid = 1'b1; opCode = 3'(op); opA = 16'(a); opB = 16'(b); dstIsOvf = dst;
    r = 0; c = 0; hasC = 0;
    case (op)
      0: r = b;
      1: begin r = (a + b) & 16'hFFFF; c = (a + b) >> 16; hasC = 1; end
      2: begin r = (longint'(a) * b) & 16'hFFFF; c = (longint'(a) * b) >> 16; hasC = 1; end
      3: begin
           hasC = 1;
           if (b != 0) begin r = a / b; c = ((longint'(a) << 16) / b) & 16'hFFFF; end
         end
      4: r = (b == 0) ? 0 : a % b;
      5: begin s = b & 15; r = a >> s; c = a & ((1 << s) - 1); hasC = 1; end
      6: r = a | b;
      default: ;
    endcase
    e.tag = tag;
    e.expData = 16'(r);
    if (op == 7) begin
      e.expValid = 1'b0;
    end else if (dst) begin
      e.expValid = 1'b0;
      modelO = hasC ? 16'(c) : 16'(r);
    end else begin
      e.expValid = 1'b1;
      if (hasC) modelO = 16'(c);
    end
    e.expOvf = modelO;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    exp_t e;
    @(negedge clk);
    opValid = 1'b0;
    e.tag = tag; e.expValid = 1'b0; e.expData = '0; e.expOvf = modelO;
    q.push_back(e);
  endtask

  // Monitor: compare after each edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      check({e.tag, " wbValid"}, wbValid, e.expValid);
      if (e.expValid) check({e.tag, " wbData"}, wbData, e.expData);
      check({e.tag, " ovf"}, ovfOut, e.expOvf);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset ovf", ovfOut, 0);
    check("R1 reset wbValid", wbValid, 0);
    rst = 1'b0;

    doOp(0, 16'h1111, 5, 0, "R8 set");
    doOp(1, 14, 5, 0, "R2 add plain");
    doOp(1, 16'hFFFE, 5, 0, "R2 add carry");
    doOp(6, 6, 5, 0, "R7 or keeps O");
    doOp(0, 0, 9, 0, "R8 set keeps O");
    doOp(1, 2, 3, 0, "R2 add clears O");
    doOp(2, 16'h345, 16'h678, 0, "R3 mul");
    doOp(4, 3, 2, 0, "R5 mod keeps O");
    doOp(4, 3, 0, 0, "R5 mod by zero");
    doOp(3, 3, 2, 0, "R4 div fraction");
    doOp(3, 1, 0, 0, "R4 div by zero");
    doOp(5, 16'h3456, 4, 0, "R6 shr 4");
    doOp(5, 16'h3456, 20, 0, "R6 shr 20 folds");
    doOp(5, 16'hFFFF, 0, 0, "R6 shr 0");
    doOp(5, 16'h8000, 15, 0, "R6 shr 15");
    doOp(2, 16'hFFFF, 16'hFFFF, 0, "R3 mul max");
    idle("R10 idle");
    doOp(7, 16'h1234, 16'h5678, 0, "R11 reserved");
    idle("R10 idle again");
    doOp(1, 16'hFFFE, 5, 0, "R2 set O to 1");
    doOp(1, 1, 5, 1, "R9 add into O no carry");
    doOp(1, 16'hFFFF, 16'hFFFF, 0, "R2 carry again");
    doOp(1, 1, 16'hFFFF, 1, "R9 add into O carry");
    doOp(0, 0, 16'h1234, 1, "R9 set into O");
    doOp(6, 16'h00F0, 16'h0F00, 1, "R9 or into O");
    doOp(4, 7, 4, 1, "R9 mod into O");
    doOp(3, 3, 2, 1, "R9 div into O");
    doOp(5, 16'h00AB, 4, 1, "R9 shr into O");
    doOp(0, 0, 16'hBEEF, 0, "R10 back to back");
    idle("R10 final idle");
    repeat (3) @(negedge clk);

    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset ovf", ovfOut, 0);
    check("R1 mid-run reset wbValid", wbValid, 0);
    rst = 1'b0;
    modelO = 0;
    repeat (2) @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule